// File: doc/BRIEF.md
# Audio Bit and Frame Clock Divider

This block turns a master audio clock into the serial bit clock and two frame (left/right) clocks that an audio serial port needs: one for the transmit direction and one for the receive direction. It runs entirely in the master audio clock domain. A 32-bit control word selects whether the port drives its own clocks or follows clocks supplied from outside. It also sets the bit-clock polarity on the pin and holds three divisors, each stored as the divisor minus one.

Next to the clock levels, the block emits single-cycle strobes at each rising and falling edge of the internal bit clock and at the start of every transmit and receive frame. A serializer can shift and sample on those strobes without detecting edges itself. Divisor updates are staged and applied only at a frame boundary, so a frame in progress is never cut short. When the port follows external clocks, the dividers are parked and the external levels are registered, with the same strobes derived from their edges. The external inputs are assumed to be already synchronized to the master clock.

Top module: `audclk_div`

## Requirements
- R1: While `rst_n` is low at a rising edge of `clk`, the next cycle shows `bit_rise`, `bit_fall`, `tx_lr`, `tx_frame`, `rx_lr` and `rx_frame` all low, and `bit_clk` equal to control bit 26. The reset is synchronous.
- R2: In master mode (control bit 27 = 0), the bit clock has a period of N master cycles, with N = bits 23:16 + 1. A field value of 0 is treated as 1, so N is at least 2. The clock is high for the first ceil(N/2) cycles of each period and low for the rest.
- R3: Control bit 26 = 1 inverts `bit_clk` at the pin. The edge strobes and frame clocks do not change with this bit.
- R4: `bit_rise` is high for exactly the one cycle in which the internal (non-inverted) bit clock has just gone high. `bit_fall` is high for the one cycle in which it has just gone low.
- R5: In master mode, the transmit frame clock has a period of M bit-clock periods, with M = bits 7:0 + 1 (a field value of 0 is treated as 1). It is high for the first ceil(M/2) bit periods and low for the rest. `tx_frame` pulses in the first cycle of the high phase, which is always a `bit_rise` cycle.
- R6: The receive frame clock follows the rule of R5 using bits 15:8, independently of the transmit divisor, with `rx_frame` as its strobe.
- R7: In the first cycle after reset is released in master mode, `bit_clk` (not inverted), `bit_rise`, `tx_lr`, `tx_frame`, `rx_lr` and `rx_frame` are all high.
- R8: A change to the bit or transmit divisor field takes effect at the next transmit frame boundary. A change to the receive field takes effect at the next receive frame boundary. The frame in progress keeps its length.
- R9: In slave mode (bit 27 = 1), the internal bit clock and both frame clocks equal `ext_bit_clk`, `ext_tx_lr` and `ext_rx_lr` from one cycle earlier, and the strobes mark their edges. The dividers are held at their reset state, so a return to master mode restarts as in R7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master audio clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ctrl | input | 32 | Clock control word: mode, polarity, three divisor fields |
| ext_bit_clk | input | 1 | External bit clock (slave mode), already synchronized |
| ext_tx_lr | input | 1 | External transmit frame clock (slave mode) |
| ext_rx_lr | input | 1 | External receive frame clock (slave mode) |
| bit_clk | output | 1 | Bit clock to the pin, polarity applied |
| bit_rise | output | 1 | Strobe: internal bit clock just rose |
| bit_fall | output | 1 | Strobe: internal bit clock just fell |
| tx_lr | output | 1 | Transmit frame clock |
| tx_frame | output | 1 | Strobe: start of a transmit frame |
| rx_lr | output | 1 | Receive frame clock |
| rx_frame | output | 1 | Strobe: start of a receive frame |

## Verification
The hardest case to reach is a frame boundary at which a staged divisor is applied while another counter is partway through its own frame. In that case the bit period changes under a receive frame that began with the old bit period. The stimulus resets with one set of divisors, rewrites all three fields early in the first transmit frame, and checks the exact cycles of every rise strobe and frame strobe across the switchover. A near-exhaustive sweep over small bit and frame divisors, odd and even, in both polarities, compares every output in every cycle with values computed from the cycle index. A slave-mode pass drives an edge pattern on the external clocks and then returns to master mode to confirm that the dividers restart cleanly.

// File: rtl/audclk_pkg.sv
`timescale 1ns/1ps
package audclk_pkg;
    localparam int DIV_W        = 8;
    localparam int CTRL_W       = 32;
    localparam int SLAVE_BIT    = 27;
    localparam int INV_BIT      = 26;
    localparam int BIT_DIV_LSB  = 16;
    localparam int RX_DIV_LSB   = 8;
    localparam int TX_DIV_LSB   = 0;
    localparam int NUM_LR       = 2;

    // ceil((div_m1 + 1) / 2): length of the high phase
    function automatic logic [DIV_W:0] high_span(input logic [DIV_W-1:0] div_m1);
        return ({1'b0, div_m1} + (DIV_W+1)'(2)) >> 1;
    endfunction

    // a stored value of zero would give a divide-by-one; lift it to one
    function automatic logic [DIV_W-1:0] at_least_one(input logic [DIV_W-1:0] f);
        return (f == '0) ? DIV_W'(1) : f;
    endfunction
endpackage

// File: rtl/audclk_bitdiv.sv
`timescale 1ns/1ps
module audclk_bitdiv
    import audclk_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             slave,
    input  logic             ext_clk,
    input  logic [DIV_W-1:0] div_field,
    input  logic             reload,
    output logic             tick,
    output logic             lvl,
    output logic             rise,
    output logic             fall
);
    typedef struct packed {
        logic [DIV_W-1:0] cnt;
        logic [DIV_W-1:0] div;
        logic             lvl;
        logic             rise;
        logic             fall;
    } bit_st_t;

    bit_st_t s_q, s_d;
    logic [DIV_W-1:0] div_new;

    assign div_new = at_least_one(div_field);
    assign tick    = !slave && (s_q.cnt == s_q.div);

    always_comb begin
        s_d = s_q;
        if (!rst_n || slave) begin
            s_d.cnt  = div_new;
            s_d.div  = div_new;
            s_d.lvl  = rst_n ? ext_clk : 1'b0;
            s_d.rise = rst_n & ext_clk & ~s_q.lvl;
            s_d.fall = rst_n & ~ext_clk & s_q.lvl;
        end else begin
            s_d.div  = reload ? div_new : s_q.div;
            s_d.cnt  = tick ? '0 : s_q.cnt + 1'b1;
            s_d.lvl  = ({1'b0, s_d.cnt} < high_span(s_d.div));
            s_d.rise = s_d.lvl & ~s_q.lvl;
            s_d.fall = ~s_d.lvl & s_q.lvl;
        end
    end

    always_ff @(posedge clk) begin
        s_q <= s_d;
    end

    assign lvl  = s_q.lvl;
    assign rise = s_q.rise;
    assign fall = s_q.fall;

    // R2
    bit_cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.cnt <= s_q.div);
    // R2
    bit_period_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> (s_q.lvl && s_q.rise));
    // R4
    bit_rise_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.rise |-> (s_q.lvl && !$past(s_q.lvl)));
    // R4
    bit_fall_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.fall |-> (!s_q.lvl && $past(s_q.lvl)));
    // R9
    bit_slave_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        slave |=> (s_q.lvl == $past(ext_clk)));
endmodule

// File: rtl/audclk_lrdiv.sv
`timescale 1ns/1ps
module audclk_lrdiv
    import audclk_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             slave,
    input  logic             tick,
    input  logic             ext_lvl,
    input  logic [DIV_W-1:0] div_field,
    output logic             wrap,
    output logic             lvl,
    output logic             fs
);
    typedef struct packed {
        logic [DIV_W-1:0] cnt;
        logic [DIV_W-1:0] div;
        logic             lvl;
        logic             fs;
    } lr_st_t;

    lr_st_t s_q, s_d;
    logic [DIV_W-1:0] div_new;

    assign div_new = at_least_one(div_field);
    assign wrap    = !slave && tick && (s_q.cnt == s_q.div);

    always_comb begin
        s_d = s_q;
        if (!rst_n || slave) begin
            s_d.cnt = div_new;
            s_d.div = div_new;
            s_d.lvl = rst_n ? ext_lvl : 1'b0;
            s_d.fs  = rst_n & ext_lvl & ~s_q.lvl;
        end else begin
            s_d.div = wrap ? div_new : s_q.div;
            if (tick) begin
                s_d.cnt = wrap ? '0 : s_q.cnt + 1'b1;
            end
            s_d.lvl = ({1'b0, s_d.cnt} < high_span(s_d.div));
            s_d.fs  = wrap;
        end
    end

    always_ff @(posedge clk) begin
        s_q <= s_d;
    end

    assign lvl = s_q.lvl;
    assign fs  = s_q.fs;

    // R5
    lr_cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.cnt <= s_q.div);
    // R5
    lr_frame_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wrap |=> (s_q.fs && s_q.lvl));
    // R5
    lr_fs_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.fs |-> (s_q.lvl && !$past(s_q.lvl)));
    // R9
    lr_slave_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        slave |=> (s_q.lvl == $past(ext_lvl)));
endmodule

// File: rtl/audclk_div.sv
`timescale 1ns/1ps
module audclk_div
    import audclk_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CTRL_W-1:0] ctrl,
    input  logic              ext_bit_clk,
    input  logic              ext_tx_lr,
    input  logic              ext_rx_lr,
    output logic              bit_clk,
    output logic              bit_rise,
    output logic              bit_fall,
    output logic              tx_lr,
    output logic              tx_frame,
    output logic              rx_lr,
    output logic              rx_frame
);
    logic              slave;
    logic              tick;
    logic              bit_lvl;
    logic [NUM_LR-1:0] lr_wrap;
    logic [NUM_LR-1:0] lr_lvl;
    logic [NUM_LR-1:0] lr_fs;
    logic [NUM_LR-1:0] lr_ext;
    logic              unused_ctrl_bits;

    assign slave            = ctrl[SLAVE_BIT];
    assign lr_ext           = {ext_rx_lr, ext_tx_lr};
    assign unused_ctrl_bits = ^{ctrl[CTRL_W-1:SLAVE_BIT+1], ctrl[INV_BIT-1:BIT_DIV_LSB+DIV_W]};

    // bit divisor is staged against the transmit frame boundary (lane 0)
    audclk_bitdiv u_bitdiv (
        .clk       (clk),
        .rst_n     (rst_n),
        .slave     (slave),
        .ext_clk   (ext_bit_clk),
        .div_field (ctrl[BIT_DIV_LSB +: DIV_W]),
        .reload    (lr_wrap[0]),
        .tick      (tick),
        .lvl       (bit_lvl),
        .rise      (bit_rise),
        .fall      (bit_fall)
    );

    for (genvar g = 0; g < NUM_LR; g++) begin : g_lane
        localparam int LSB = (g == 0) ? TX_DIV_LSB : RX_DIV_LSB;
        audclk_lrdiv u_lrdiv (
            .clk       (clk),
            .rst_n     (rst_n),
            .slave     (slave),
            .tick      (tick),
            .ext_lvl   (lr_ext[g]),
            .div_field (ctrl[LSB +: DIV_W]),
            .wrap      (lr_wrap[g]),
            .lvl       (lr_lvl[g]),
            .fs        (lr_fs[g])
        );
    end

    assign bit_clk  = bit_lvl ^ ctrl[INV_BIT];
    assign tx_lr    = lr_lvl[0];
    assign tx_frame = lr_fs[0];
    assign rx_lr    = lr_lvl[1];
    assign rx_frame = lr_fs[1];

    // R5
    tx_frame_on_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !slave |=> (tx_frame -> bit_rise));
    // R6
    rx_frame_on_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !slave |=> (rx_frame -> bit_rise));
    // R6
    rx_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lr_wrap[1] |=> rx_frame);
    // R4
    no_dual_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({bit_rise, bit_fall}));
endmodule

// File: tb/audclk_div_tb.sv
`timescale 1ns/1ps
module audclk_div_tb;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 150000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] ctrl = '0;
    logic        ext_bit_clk = 1'b0;
    logic        ext_tx_lr = 1'b0;
    logic        ext_rx_lr = 1'b0;
    logic        bit_clk, bit_rise, bit_fall, tx_lr, tx_frame, rx_lr, rx_frame;

    int tests = 0;
    int fails = 0;
    int cyc = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    audclk_div u_dut (
        .clk(clk), .rst_n(rst_n), .ctrl(ctrl),
        .ext_bit_clk(ext_bit_clk), .ext_tx_lr(ext_tx_lr), .ext_rx_lr(ext_rx_lr),
        .bit_clk(bit_clk), .bit_rise(bit_rise), .bit_fall(bit_fall),
        .tx_lr(tx_lr), .tx_frame(tx_frame), .rx_lr(rx_lr), .rx_frame(rx_frame)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == WATCHDOG) begin
            fails = fails + 1;
            $display("FAIL watchdog act=%0d cycles exp=finish", cyc);
            $display("  [TB] %0d tests run, %0d failed", tests + 1, fails);
            $finish;
        end
    end

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        tests = tests + 1;
        if (act !== exp) begin
            fails = fails + 1;
            $display("FAIL %s act=%h exp=%h (t=%0t)", tag, act, exp, $time);
        end
    endtask

    function automatic logic [31:0] mk(input bit slv, input bit inv, input int bf, input int rf, input int tf);
        return (32'(slv) << 27) | (32'(inv) << 26) | (32'(bf) << 16) | (32'(rf) << 8) | 32'(tf);
    endfunction

    task automatic do_reset(input logic [31:0] c);
        @(negedge clk);
        rst_n = 1'b0;
        ctrl  = c;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic step;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic sweep_one(input int bf, input int tf, input int rf, input bit inv);
        int n, mt, mr, len;
        n  = ((bf == 0) ? 1 : bf) + 1;
        mt = ((tf == 0) ? 1 : tf) + 1;
        mr = ((rf == 0) ? 1 : rf) + 1;
        len = 2 * n * mt * mr;
        do_reset(mk(1'b0, inv, bf, rf, tf));
        for (int k = 0; k < len; k++) begin
            int p, j, it, ir;
            logic bl, el, etx, erx;
            step();
            p   = k % n;
            j   = k / n;
            it  = j % mt;
            ir  = j % mr;
            bl  = (p < (n + 1) / 2);
            etx = (it < (mt + 1) / 2);
            erx = (ir < (mr + 1) / 2);
            el  = bl ^ inv;
            // R2 R3: bit clock shape and pin polarity
            check("R2/R3 bit_clk", {7'd0, bit_clk}, {7'd0, el});
            // R4: edge strobes independent of polarity
            check("R4 strobes", {6'd0, bit_rise, bit_fall},
                  {6'd0, (p == 0), (p == (n + 1) / 2)});
            // R5: transmit frame clock
            check("R5 tx", {6'd0, tx_lr, tx_frame}, {6'd0, etx, (p == 0 && it == 0)});
            // R6: receive frame clock
            check("R6 rx", {6'd0, rx_lr, rx_frame}, {6'd0, erx, (p == 0 && ir == 0)});
            if (k == 0) begin
                // R7: first cycle after release opens everything
                check("R7 first cycle", {2'd0, bit_clk ^ inv, bit_rise, tx_lr, tx_frame, rx_lr, rx_frame},
                      8'h3f);
            end
        end
    endtask

    initial begin
        // R1: reset state, with the polarity bit set
        rst_n = 1'b0;
        ctrl  = mk(1'b0, 1'b1, 3, 3, 3);
        repeat (3) @(negedge clk);
        check("R1 reset outputs", {1'b0, bit_clk, bit_rise, bit_fall, tx_lr, tx_frame, rx_lr, rx_frame},
              8'h40);

        // R2..R7: sweep of small divisors
        for (int bf = 0; bf < 5; bf++) begin
            for (int ti = 0; ti < 3; ti++) begin
                for (int ri = 0; ri < 2; ri++) begin
                    for (int inv = 0; inv < 2; inv++) begin
                        int tf, rf;
                        tf = (ti == 0) ? 0 : ((ti == 1) ? 1 : 3);
                        rf = (ri == 0) ? 2 : 4;
                        sweep_one(bf, tf, rf, inv[0]);
                    end
                end
            end
        end

        // R8: staged divisors; N=4, Mtx=4, Mrx=6, then all fields to 1 at k=5
        do_reset(mk(1'b0, 1'b0, 3, 5, 3));
        for (int k = 0; k < 28; k++) begin
            logic er, et, erx;
            step();
            if (k == 5) ctrl = mk(1'b0, 1'b0, 1, 1, 1);
            er  = (k < 16) ? (k % 4 == 0) : (k % 2 == 0);
            et  = (k == 0) || (k == 16) || (k == 20) || (k == 24);
            erx = (k == 0) || (k == 20) || (k == 24);
            check("R8 rise timing", {7'd0, bit_rise}, {7'd0, er});
            check("R8 tx boundary", {7'd0, tx_frame}, {7'd0, et});
            check("R8 rx boundary", {7'd0, rx_frame}, {7'd0, erx});
        end

        // R9: slave pass-through and strobes from external edges
        do_reset(mk(1'b1, 1'b0, 3, 3, 3));
        begin
            logic pb, pt, pr;
            pb = 1'b0; pt = 1'b0; pr = 1'b0;
            step();
            for (int i = 0; i < 16; i++) begin
                logic eb, et, er;
                eb = 1'(i ^ (i >> 2));
                et = 1'(i >> 2);
                er = 1'(i >> 3);
                ext_bit_clk = eb;
                ext_tx_lr   = et;
                ext_rx_lr   = er;
                step();
                check("R9 slave follow",
                      {1'b0, bit_clk, bit_rise, bit_fall, tx_lr, tx_frame, rx_lr, rx_frame},
                      {1'b0, eb, eb & ~pb, ~eb & pb, et, et & ~pt, er, er & ~pr});
                pb = eb; pt = et; pr = er;
            end
        end
        ext_bit_clk = 1'b0;
        ext_tx_lr   = 1'b0;
        ext_rx_lr   = 1'b0;
        step();
        step();
        // R9: back to master, N=2, M=2 both, restarts like R7
        ctrl = mk(1'b0, 1'b0, 1, 1, 1);
        for (int k = 0; k < 8; k++) begin
            step();
            check("R9 restart after slave",
                  {3'd0, bit_clk, bit_rise, tx_frame, rx_frame, tx_lr},
                  {3'd0, (k % 2 == 0), (k % 2 == 0), (k % 4 == 0), (k % 4 == 0), (k % 4 < 2)});
        end

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule